// File: doc/BRIEF.md
# Two-Wire Bus Slave with Clock Stretching

This block is a serial two-wire bus slave that responds to a 7-bit address supplied on an input port. A local processor talks to it through three things: a transmit holding register it writes, a receive holding register it reads, and a set of status flags. The block watches the bus for START, repeated START and STOP conditions. It acknowledges its own address and the general call address, and it then moves bytes in either direction through one shift register.

On a write transfer the block receives bytes and hands each one to the processor. On a read transfer it sends the bytes the processor supplies. If the processor has not serviced the relevant holding register in time, the block holds the clock line low until the processor does. Both bus lines are open-drain. The block only ever pulls a line low, through an output-enable port.

Top module: `i2cs_slave`

## Requirements
- R1: After reset, tx_ready_o is 1, and rx_ready_o, nack_o, xfer_done_o, addressed_o, read_dir_o, gen_call_o, clk_hold_o, scl_oe_o and sda_oe_o are all 0.
- R2: After a START, the first 8 bits, taken MSB first, form the address byte: bits 7..1 are the address and bit 0 is the direction, where 1 means the master reads. If the address equals own_addr_i, the slave pulls SDA low during the ninth clock, sets addressed_o, and copies the direction bit to read_dir_o. If it does not match, the slave leaves SDA released and addressed_o stays 0.
- R3: In a write transfer, each received byte is placed in the receive holding register and sets rx_ready_o. The slave acknowledges that byte. A pulse on rhr_rd_i clears rx_ready_o.
- R4: If rx_ready_o is still 1 when a new byte has been received, the slave holds SCL low and raises clk_hold_o. The earlier byte stays readable on rhr_data_o. One system clock after the processor reads it, the new byte is loaded, acknowledged and flagged, and SCL is released.
- R5: A pulse on thr_wr_i stores the byte and clears tx_ready_o. In a read transfer, that byte is shifted out MSB first. tx_ready_o stays 0 until the master's acknowledge bit for that byte has been sampled, and it becomes 1 at that point.
- R6: If tx_ready_o is 1 when a read transfer needs the next byte, the slave holds SCL low and raises clk_hold_o until thr_wr_i is pulsed. The newly written byte is then the one sent.
- R7: A master NACK (SDA high in the ninth clock of a sent byte) sets nack_o and also sets tx_ready_o. After that, the slave drives no data until the next START or STOP.
- R8: A STOP while addressed, or a repeated START followed by a non-matching address, sets xfer_done_o and clears addressed_o. A repeated START followed by a matching address keeps addressed_o set. Any address match clears xfer_done_o, nack_o and gen_call_o, except that a general call match sets gen_call_o.
- R9: An address byte of 0x00 is acknowledged as a general call. It sets gen_call_o and addressed_o with read_dir_o at 0. The bytes that follow are delivered as in R3, with no interpretation.
- R10: sda_oe_o changes only while the synchronised SCL is low. scl_oe_o is asserted only while the synchronised SCL is low. clk_hold_o equals scl_oe_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe_o | output | 1 | Pull SCL low (stretch) |
| sda_oe_o | output | 1 | Pull SDA low |
| own_addr_i | input | 7 | Slave address |
| thr_wr_i | input | 1 | Write strobe for transmit holding register |
| thr_data_i | input | 8 | Byte to transmit |
| rhr_rd_i | input | 1 | Read strobe for receive holding register |
| rhr_data_o | output | 8 | Last received byte |
| tx_ready_o | output | 1 | Transmit holding register may be written |
| rx_ready_o | output | 1 | Receive holding register holds an unread byte |
| nack_o | output | 1 | Master did not acknowledge a sent byte |
| xfer_done_o | output | 1 | Addressed transfer has ended |
| addressed_o | output | 1 | Slave is selected |
| read_dir_o | output | 1 | Direction bit of the last matched address |
| clk_hold_o | output | 1 | Clock is being stretched |
| gen_call_o | output | 1 | General call was received |

## Verification
Some properties are checked on every cycle. SDA drive changes only while the clock is low. Clock stretching occurs only while the line is low. The completion flag and the selected flag are never set together. A receive or transmit ready flag rises only when the direction of the active transfer allows it. Other behaviour can only be shown by the bench's bus-level scenarios. These include the values of the shifted bytes, when each ready flag changes relative to the ninth clock, the release of a stretch one clock after service, silence after a NACK, and the way a repeated START with a matching or a foreign address ends or continues the transfer.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RECV,
    ST_ACK,
    ST_RX_HOLD,
    ST_TX_HOLD,
    ST_SEND,
    ST_SAMPLE,
    ST_SAMPLE_END
  } state_e;
endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff[0] <= scl_i;
      sda_ff[0] <= sda_i;
      for (int i = 1; i < STAGES; i++) begin
        scl_ff[i] <= scl_ff[i-1];
        sda_ff[i] <= sda_ff[i-1];
      end
      scl_q <= scl_ff[STAGES-1];
      sda_q <= sda_ff[STAGES-1];
    end
  end

  assign scl_o      = scl_ff[STAGES-1];
  assign sda_o      = sda_ff[STAGES-1];
  assign scl_rise_o = scl_o & ~scl_q;
  assign scl_fall_o = ~scl_o & scl_q;
  assign start_o    = scl_o & scl_q & sda_q & ~sda_o;
  assign stop_o     = scl_o & scl_q & ~sda_q & sda_o;
endmodule

// File: rtl/i2cs_hold.sv
module i2cs_hold #(
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              thr_wr_i,
  input  logic [BYTE_W-1:0] thr_data_i,
  input  logic              rhr_rd_i,
  input  logic              rx_load_i,
  input  logic [BYTE_W-1:0] rx_byte_i,
  input  logic              tx_done_i,
  output logic [BYTE_W-1:0] thr_o,
  output logic              tx_ready_o,
  output logic [BYTE_W-1:0] rhr_o,
  output logic              rx_ready_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      thr_o      <= '0;
      tx_ready_o <= 1'b1;
      rhr_o      <= '0;
      rx_ready_o <= 1'b0;
    end else begin
      if (thr_wr_i) begin
        thr_o      <= thr_data_i;
        tx_ready_o <= 1'b0;
      end else if (tx_done_i) begin
        tx_ready_o <= 1'b1;
      end
      // a load in the same cycle as a read wins: the new byte is unread
      if (rx_load_i) begin
        rhr_o      <= rx_byte_i;
        rx_ready_o <= 1'b1;
      end else if (rhr_rd_i) begin
        rx_ready_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/i2cs_engine.sv
module i2cs_engine
  import i2cs_pkg::*;
#(
  parameter int ADDR_W = 7,
  localparam int BYTE_W = ADDR_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_s_i,
  input  logic              sda_s_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic              tx_ready_i,
  input  logic [BYTE_W-1:0] thr_i,
  input  logic              rx_ready_i,
  output logic              rx_load_o,
  output logic [BYTE_W-1:0] rx_byte_o,
  output logic              tx_done_o,
  output logic              scl_oe_o,
  output logic              sda_oe_o,
  output logic              addressed_o,
  output logic              read_dir_o,
  output logic              nack_o,
  output logic              xfer_done_o,
  output logic              gen_call_o
);
  localparam int CNT_W = $clog2(BYTE_W + 1);

  state_e            state;
  logic [BYTE_W-1:0] shreg;
  logic [CNT_W-1:0]  cnt;
  logic              addr_phase, to_send;
  logic              own_hit, gc_hit, byte_full, bus_evt;

  always_comb begin
    own_hit   = shreg[BYTE_W-1:1] == own_addr_i;
    gc_hit    = shreg == '0;
    byte_full = cnt == CNT_W'(BYTE_W);
    bus_evt   = start_i | stop_i;
    rx_load_o = !bus_evt &&
                ((state == ST_RECV && scl_fall_i && byte_full && !addr_phase && !rx_ready_i) ||
                 (state == ST_RX_HOLD && !rx_ready_i));
    tx_done_o = !bus_evt && state == ST_SAMPLE && scl_rise_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state       <= ST_IDLE;
      shreg       <= '0;
      cnt         <= '0;
      addr_phase  <= 1'b1;
      to_send     <= 1'b0;
      addressed_o <= 1'b0;
      read_dir_o  <= 1'b0;
      nack_o      <= 1'b0;
      xfer_done_o <= 1'b0;
      gen_call_o  <= 1'b0;
    end else if (stop_i) begin
      state <= ST_IDLE;
      if (addressed_o) begin
        xfer_done_o <= 1'b1;
        addressed_o <= 1'b0;
      end
    end else if (start_i) begin
      state      <= ST_RECV;
      cnt        <= '0;
      addr_phase <= 1'b1;
    end else begin
      unique case (state)
        ST_RECV: begin
          if (scl_rise_i) begin
            shreg <= {shreg[BYTE_W-2:0], sda_s_i};
            cnt   <= cnt + 1'b1;
          end else if (scl_fall_i && byte_full) begin
            if (addr_phase) begin
              if (own_hit || gc_hit) begin
                addressed_o <= 1'b1;
                read_dir_o  <= shreg[0];
                to_send     <= shreg[0];
                gen_call_o  <= gc_hit;
                nack_o      <= 1'b0;
                xfer_done_o <= 1'b0;
                state       <= ST_ACK;
              end else begin
                state <= ST_IDLE;
                if (addressed_o) begin
                  xfer_done_o <= 1'b1;
                  addressed_o <= 1'b0;
                end
              end
            end else begin
              to_send <= 1'b0;
              state   <= rx_ready_i ? ST_RX_HOLD : ST_ACK;
            end
          end
        end
        ST_RX_HOLD: if (!rx_ready_i) state <= ST_ACK;
        ST_ACK, ST_SAMPLE_END: begin
          if (scl_fall_i) begin
            cnt        <= '0;
            addr_phase <= 1'b0;
            if (!to_send) state <= ST_RECV;
            else if (tx_ready_i) state <= ST_TX_HOLD;
            else begin
              shreg <= thr_i;
              state <= ST_SEND;
            end
          end
        end
        ST_TX_HOLD: begin
          if (!tx_ready_i) begin
            shreg <= thr_i;
            state <= ST_SEND;
          end
        end
        ST_SEND: begin
          if (scl_fall_i) begin
            if (cnt == CNT_W'(BYTE_W - 1)) state <= ST_SAMPLE;
            else begin
              shreg <= {shreg[BYTE_W-2:0], 1'b0};
              cnt   <= cnt + 1'b1;
            end
          end
        end
        ST_SAMPLE: begin
          if (scl_rise_i) begin
            if (sda_s_i) begin
              nack_o <= 1'b1;
              state  <= ST_IDLE;
            end else state <= ST_SAMPLE_END;
          end
        end
        default: ;
      endcase
    end
  end

  assign rx_byte_o = shreg;
  assign scl_oe_o  = state == ST_RX_HOLD || state == ST_TX_HOLD;
  assign sda_oe_o  = state == ST_ACK || (state == ST_SEND && !shreg[BYTE_W-1]);

  // R10
  sda_low_scl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> !scl_s_i);
  // R10
  stretch_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scl_oe_o |-> !scl_s_i);
  // R8
  done_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(xfer_done_o && addressed_o));
endmodule

// File: rtl/i2cs_slave.sv
module i2cs_slave #(
  parameter int ADDR_W      = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe_o,
  output logic              sda_oe_o,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic              thr_wr_i,
  input  logic [ADDR_W:0]   thr_data_i,
  input  logic              rhr_rd_i,
  output logic [ADDR_W:0]   rhr_data_o,
  output logic              tx_ready_o,
  output logic              rx_ready_o,
  output logic              nack_o,
  output logic              xfer_done_o,
  output logic              addressed_o,
  output logic              read_dir_o,
  output logic              clk_hold_o,
  output logic              gen_call_o
);
  localparam int BYTE_W = ADDR_W + 1;

  logic scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic rx_load, tx_done, scl_oe;
  logic [BYTE_W-1:0] rx_byte, thr_q;

  i2cs_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_evt), .stop_o(stop_evt)
  );

  i2cs_engine #(.ADDR_W(ADDR_W)) u_engine (
    .clk_i, .rst_ni, .scl_s_i(scl_s), .sda_s_i(sda_s),
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start_evt), .stop_i(stop_evt), .own_addr_i,
    .tx_ready_i(tx_ready_o), .thr_i(thr_q), .rx_ready_i(rx_ready_o),
    .rx_load_o(rx_load), .rx_byte_o(rx_byte), .tx_done_o(tx_done),
    .scl_oe_o(scl_oe), .sda_oe_o, .addressed_o, .read_dir_o,
    .nack_o, .xfer_done_o, .gen_call_o
  );

  i2cs_hold #(.BYTE_W(BYTE_W)) u_hold (
    .clk_i, .rst_ni, .thr_wr_i, .thr_data_i, .rhr_rd_i,
    .rx_load_i(rx_load), .rx_byte_i(rx_byte), .tx_done_i(tx_done),
    .thr_o(thr_q), .tx_ready_o, .rhr_o(rhr_data_o), .rx_ready_o
  );

  assign scl_oe_o   = scl_oe;
  assign clk_hold_o = scl_oe;

  // R3
  rx_dir_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_ready_o) |-> addressed_o && !read_dir_o);
  // R5
  tx_dir_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_ready_o) |-> read_dir_o);
endmodule

// File: tb/i2cs_slave_bench.sv
module i2cs_slave_bench;
  localparam int H = 20;
  localparam logic [6:0] OWN = 7'h2A;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic scl_bus, sda_bus;
  logic scl_oe, sda_oe;
  logic thr_wr = 1'b0, rhr_rd = 1'b0;
  logic [7:0] thr_data = '0, rhr_data;
  logic tx_ready, rx_ready, nack, xfer_done, addressed, read_dir, clk_hold, gen_call;
  int n_chk = 0, n_fail = 0;

  assign scl_bus = scl_m & ~scl_oe;
  assign sda_bus = sda_m & ~sda_oe;

  i2cs_slave u_i2cs_slave (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_bus), .sda_i(sda_bus),
    .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .own_addr_i(OWN),
    .thr_wr_i(thr_wr), .thr_data_i(thr_data), .rhr_rd_i(rhr_rd), .rhr_data_o(rhr_data),
    .tx_ready_o(tx_ready), .rx_ready_o(rx_ready), .nack_o(nack), .xfer_done_o(xfer_done),
    .addressed_o(addressed), .read_dir_o(read_dir), .clk_hold_o(clk_hold), .gen_call_o(gen_call)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_high();
    while (!scl_bus) @(negedge clk);
  endtask

  task automatic m_start();
    sda_m = 1'b1; scl_m = 1'b1; wt(H);
    sda_m = 1'b0; wt(H);
    scl_m = 1'b0; wt(H);
  endtask

  task automatic m_rstart();
    sda_m = 1'b1; wt(H);
    scl_m = 1'b1; wait_high(); wt(H);
    sda_m = 1'b0; wt(H);
    scl_m = 1'b0; wt(H);
  endtask

  task automatic m_stop();
    sda_m = 1'b0; wt(H);
    scl_m = 1'b1; wait_high(); wt(H);
    sda_m = 1'b1; wt(H);
  endtask

  task automatic m_wbit(input logic b);
    sda_m = b; wt(H);
    scl_m = 1'b1; wait_high(); wt(H);
    scl_m = 1'b0; wt(H);
  endtask

  task automatic m_rbit(output logic b);
    sda_m = 1'b1; wt(H);
    scl_m = 1'b1; wait_high(); wt(H/2);
    b = sda_bus; wt(H/2);
    scl_m = 1'b0; wt(H);
  endtask

  task automatic m_wbyte(input logic [7:0] d, output logic ack);
    for (int i = 7; i >= 0; i--) m_wbit(d[i]);
    m_rbit(ack);
  endtask

  task automatic m_rbyte(output logic [7:0] d);
    for (int i = 7; i >= 0; i--) m_rbit(d[i]);
  endtask

  task automatic cpu_wr(input logic [7:0] d);
    thr_data = d; thr_wr = 1'b1; @(negedge clk);
    thr_wr = 1'b0; @(negedge clk);
  endtask

  task automatic cpu_rd(output logic [7:0] d);
    d = rhr_data; rhr_rd = 1'b1; @(negedge clk);
    rhr_rd = 1'b0; @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 tx_ready", tx_ready, 1);
    chk("R1 rx_ready", rx_ready, 0);
    chk("R1 flags", {nack, xfer_done, addressed, read_dir, gen_call}, 0);
    chk("R1 drives", {clk_hold, scl_oe, sda_oe}, 0);
  endtask

  task automatic t_addr_miss();
    logic ack;
    m_start();
    m_wbyte({OWN ^ 7'h01, 1'b0}, ack);
    chk("R2 foreign address not acked", ack, 1);
    chk("R2 foreign address not selected", addressed, 0);
    m_stop();
    chk("R8 stop without access", xfer_done, 0);
  endtask

  task automatic t_write();
    logic ack; logic [7:0] d;
    m_start();
    m_wbyte({OWN, 1'b0}, ack);
    chk("R2 own address acked", ack, 0);
    chk("R2 selected", addressed, 1);
    chk("R2 direction write", read_dir, 0);
    chk("R9 no general call", gen_call, 0);
    m_wbyte(8'hA5, ack);
    chk("R3 data acked", ack, 0);
    chk("R3 rx_ready set", rx_ready, 1);
    cpu_rd(d);
    chk("R3 byte A5", d, 8'hA5);
    chk("R3 rx_ready cleared", rx_ready, 0);
    m_wbyte(8'h3C, ack);
    cpu_rd(d);
    chk("R3 byte 3C", d, 8'h3C);
    m_stop();
    chk("R8 stop sets done", xfer_done, 1);
    chk("R8 stop deselects", addressed, 0);
  endtask

  task automatic t_rx_stretch();
    logic ack; logic [7:0] d;
    m_start();
    m_wbyte({OWN, 1'b0}, ack);
    chk("R8 match clears done", xfer_done, 0);
    m_wbyte(8'h11, ack);
    fork
      m_wbyte(8'h22, ack);
      begin
        while (!clk_hold) @(negedge clk);
        wt(40);
        chk("R4 hold asserted", clk_hold, 1);
        chk("R4 scl held low", scl_bus, 0);
        chk("R10 scl_oe matches hold", scl_oe, clk_hold);
        cpu_rd(d);
        chk("R4 first byte kept", d, 8'h11);
      end
    join
    chk("R4 held byte acked", ack, 0);
    chk("R4 hold released", clk_hold, 0);
    chk("R4 rx_ready after release", rx_ready, 1);
    cpu_rd(d);
    chk("R4 second byte", d, 8'h22);
    m_stop();
  endtask

  task automatic t_read();
    logic ack, b; logic [7:0] d;
    cpu_wr(8'h96);
    chk("R5 write clears tx_ready", tx_ready, 0);
    m_start();
    m_wbyte({OWN, 1'b1}, ack);
    chk("R2 read address acked", ack, 0);
    chk("R2 direction read", read_dir, 1);
    m_rbyte(d);
    chk("R5 byte 96 MSB first", d, 8'h96);
    chk("R5 tx_ready waits for ack bit", tx_ready, 0);
    m_wbit(1'b0);
    chk("R5 tx_ready after ack", tx_ready, 1);
    chk("R7 no nack on ack", nack, 0);
    fork
      m_rbyte(d);
      begin
        while (!clk_hold) @(negedge clk);
        wt(40);
        chk("R6 hold asserted", clk_hold, 1);
        chk("R6 scl held low", scl_bus, 0);
        cpu_wr(8'h5B);
      end
    join
    chk("R6 late byte sent", d, 8'h5B);
    m_wbit(1'b1);
    chk("R7 nack flagged", nack, 1);
    chk("R7 tx_ready after nack", tx_ready, 1);
    m_rbit(b);
    chk("R7 silent after nack", b, 1);
    chk("R7 no stretch after nack", clk_hold, 0);
    m_stop();
    chk("R8 read ends done", xfer_done, 1);
  endtask

  task automatic t_gen_call();
    logic ack; logic [7:0] d;
    m_start();
    m_wbyte(8'h00, ack);
    chk("R9 general call acked", ack, 0);
    chk("R9 gen_call set", gen_call, 1);
    chk("R9 selected write", {addressed, read_dir}, 2'b10);
    chk("R8 match clears nack", nack, 0);
    m_wbyte(8'h04, ack);
    chk("R9 command byte acked", ack, 0);
    cpu_rd(d);
    chk("R9 command byte raw", d, 8'h04);
    m_stop();
  endtask

  task automatic t_rep_start();
    logic ack; logic [7:0] d;
    m_start();
    m_wbyte({OWN, 1'b0}, ack);
    chk("R8 own match clears gen_call", gen_call, 0);
    m_wbyte(8'h77, ack);
    cpu_rd(d);
    chk("R3 byte 77", d, 8'h77);
    m_rstart();
    m_wbyte({OWN, 1'b0}, ack);
    chk("R8 rstart own acked", ack, 0);
    chk("R8 rstart own keeps selection", {addressed, xfer_done}, 2'b10);
    m_rstart();
    m_wbyte({7'h15, 1'b0}, ack);
    chk("R8 rstart foreign not acked", ack, 1);
    chk("R8 rstart foreign ends", {addressed, xfer_done}, 2'b01);
    m_stop();
    chk("R8 done holds", xfer_done, 1);
  endtask

  initial begin
    wt(5);
    rst_n = 1'b1;
    wt(5);
    t_reset();
    t_addr_miss();
    t_write();
    t_rx_stretch();
    t_read();
    t_gen_call();
    t_rep_start();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule